// File: doc/BRIEF.md
# GPIO Edge Detect Unit

This block watches a bank of general-purpose input pins and records edge events on each one. Each pin has two enable bits, one for rising edges and one for falling edges. When both are set, the pin reports either edge. An enabled edge sets a sticky status bit for that pin. The bit stays set until software writes a one to its position in the status register. Clearing both enable bits for a pin masks it: no new events are recorded on that pin.

The pins are sampled through a two-flop synchroniser, and edges are found by comparing the synchronised sample with the sample from the cycle before. The lowest status bits each drive their own interrupt request line. The remaining status bits are ORed into one shared request line. Software services that line by clearing every set bit in the upper group in a single write, then reading the status again, and repeating until the upper group is empty. Register access uses a plain synchronous port, and read data appears one cycle after the read request.

Top module: `gpio_edge_unit`

## Requirements
- R1: After reset, both enable registers and the status register read as zero and every interrupt output is low.
- R2: A pin whose rising-enable bit (register address 0, bit = pin number) is set records a low-to-high change. The status bit and its request output go high on the third rising clock edge after the pin changes. A high-to-low change on that pin records nothing.
- R3: A pin whose falling-enable bit (address 1, bit = pin number) is set records a high-to-low change. A low-to-high change on that pin records nothing.
- R4: A pin with both enable bits set records both kinds of change.
- R5: A pin with neither enable bit set never sets its status bit, however it toggles.
- R6: A status bit (address 2, bit = pin number) stays set until a write to address 2 has a one in that bit position. That write clears the bit on the next clock edge. Bits written as zero keep their value.
- R7: If a write-one-to-clear and a newly detected edge hit the same status bit in the same cycle, the bit stays set.
- R8: For pins 0 to 10, interrupt output irq_direct[n] follows status bit n.
- R9: irq_shared is high while any status bit from 11 to 27 is set. It goes low on the clock edge that clears the last such bit.
- R10: A read at address 0, 1 or 2 returns the rising-enable, falling-enable or status register, and address 3 returns zero. rdata is updated on the clock edge that samples rd_en. Bits 31 to 28 always read as zero, and writes to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 28 | Asynchronous general-purpose input pins |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 rising enable, 1 falling enable, 2 status, 3 reserved |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_direct | output | 11 | Per-pin request lines for pins 0 to 10 |
| irq_shared | output | 1 | Combined request line for pins 11 to 27 |

## Verification
The assertions are checked on every cycle. They cover the following:
- Status bits never drop unless a one was written to them.
- No status bit rises unless one of its enables was set.
- The reserved address and the unused upper bits read as zero.
- The request lines are low right after reset.

Some behaviours depend on stimulus that a property cannot create, so only the directed scenarios show them:
- the exact three-edge detection latency,
- the direction selectivity of each enable,
- the clear that coincides with a fresh edge,
- the shared line dropping once its last source is cleared.

// File: rtl/gpio_edge_unit.sv
`timescale 1ns/1ps
module gpio_edge_unit #(
  parameter int NPINS   = 28,
  parameter int NDIRECT = 11,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   pin_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [1:0]         addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic [NDIRECT-1:0] irq_direct,
  output logic               irq_shared
);
  localparam logic [1:0] A_RISE = 2'd0;
  localparam logic [1:0] A_FALL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [DW-1:0] PIN_MASK = {{(DW-NPINS){1'b0}}, {NPINS{1'b1}}};
  localparam logic [DW-1:0] SHR_MASK = PIN_MASK & ~{{(DW-NDIRECT){1'b0}}, {NDIRECT{1'b1}}};

  logic [NPINS-1:0] sync_a, sync_b, prev_q;
  logic [DW-1:0]    rise_en_q, fall_en_q, status_q, rdata_q;
  logic [DW-1:0]    hit, clr, wmask;

  assign wmask = wdata & PIN_MASK;
  assign hit   = ({{(DW-NPINS){1'b0}}, sync_b & ~prev_q} & rise_en_q)
               | ({{(DW-NPINS){1'b0}}, ~sync_b & prev_q} & fall_en_q);
  assign clr   = (wr_en && addr == A_STAT) ? wmask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      prev_q <= '0;
    end else begin
      sync_a <= pin_in;
      sync_b <= sync_a;
      prev_q <= sync_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      status_q  <= '0;
    end else begin
      if (wr_en && addr == A_RISE) rise_en_q <= wmask;
      if (wr_en && addr == A_FALL) fall_en_q <= wmask;
      status_q <= ((status_q & ~clr) | hit) & PIN_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_en) begin
      case (addr)
        A_RISE:  rdata_q <= rise_en_q;
        A_FALL:  rdata_q <= fall_en_q;
        A_STAT:  rdata_q <= status_q;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign rdata      = rdata_q;
  assign irq_direct = status_q[NDIRECT-1:0];
  assign irq_shared = |(status_q & SHR_MASK);
endmodule

// File: rtl/gpio_edge_unit_chk.sv
`timescale 1ns/1ps
module gpio_edge_unit_chk #(
  parameter int NPINS   = 28,
  parameter int NDIRECT = 11,
  parameter int DW      = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [1:0]         addr,
  input logic [DW-1:0]      wdata,
  input logic [DW-1:0]      rdata,
  input logic [NDIRECT-1:0] irq_direct,
  input logic               irq_shared,
  input logic [DW-1:0]      rise_en,
  input logic [DW-1:0]      fall_en,
  input logic [DW-1:0]      status
);
  logic [DW-1:0] clr_req;
  assign clr_req = (wr_en && addr == 2'd2) ? wdata : '0;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (irq_direct == '0 && !irq_shared && rdata == '0));

  // R6
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~$past(clr_req)) & ~status) == '0));

  // R5
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status & ~$past(status)) & ~($past(rise_en) | $past(fall_en))) == '0));

  // R10
  reserved_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |=> (rdata == '0));

  // R10
  upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rdata[DW-1:NPINS] == '0));
endmodule

bind gpio_edge_unit gpio_edge_unit_chk #(.NPINS(NPINS), .NDIRECT(NDIRECT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq_direct(irq_direct), .irq_shared(irq_shared),
  .rise_en(rise_en_q), .fall_en(fall_en_q), .status(status_q)
);

// File: tb/test_gpio_edge_unit.sv
`timescale 1ns/1ps
module test_gpio_edge_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] pins = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [10:0] irq_direct;
  logic        irq_shared;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_edge_unit i_gpio_edge_unit (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_direct(irq_direct), .irq_shared(irq_shared)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk); pins[p] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(2'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_direct", {21'b0, irq_direct}, 32'h0);
    chk("R1 irq_shared", {31'b0, irq_shared}, 32'h0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R1 reg reset", d, 32'h0);
    end
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(2'd0, 32'h1 << 3);
    @(negedge clk); pins[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2 not yet set", {21'b0, irq_direct}, 32'h0);
    @(negedge clk);
    chk("R2 R8 irq_direct[3]", {21'b0, irq_direct}, 32'h1 << 3);
    rd(2'd2, d);
    chk("R2 status", d, 32'h1 << 3);
    clear_all();
    set_pin(3, 1'b0);
    rd(2'd2, d);
    chk("R2 fall ignored", d, 32'h0);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    wr(2'd1, 32'h1 << 20);
    set_pin(20, 1'b1);
    chk("R3 rise ignored", {31'b0, irq_shared}, 32'h0);
    set_pin(20, 1'b0);
    chk("R3 R9 irq_shared", {31'b0, irq_shared}, 32'h1);
    rd(2'd2, d);
    chk("R3 status", d, 32'h1 << 20);
    clear_all();
    wr(2'd1, 32'h0);
  endtask

  task automatic t_both();
    logic [31:0] d;
    wr(2'd0, 32'h1 << 5);
    wr(2'd1, 32'h1 << 5);
    set_pin(5, 1'b1);
    rd(2'd2, d);
    chk("R4 rise seen", d, 32'h1 << 5);
    clear_all();
    set_pin(5, 1'b0);
    rd(2'd2, d);
    chk("R4 fall seen", d, 32'h1 << 5);
    clear_all();
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    for (int k = 0; k < 4; k++) set_pin(7, ~pins[7]);
    set_pin(14, 1'b1);
    set_pin(14, 1'b0);
    rd(2'd2, d);
    chk("R5 masked pins", d, 32'h0);
    chk("R5 no irq", {20'b0, irq_shared, irq_direct}, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(2'd0, (32'h1 << 3) | (32'h1 << 15) | (32'h1 << 25));
    @(negedge clk); pins[3] = 1'b1; pins[15] = 1'b1; pins[25] = 1'b1;
    repeat (3) @(negedge clk);
    wr(2'd2, 32'h0);
    rd(2'd2, d);
    chk("R6 zero write keeps", d, 32'h0200_8008);
    wr(2'd2, 32'h1 << 15);
    rd(2'd2, d);
    chk("R6 single clear", d, 32'h0200_0008);
    chk("R9 still high", {31'b0, irq_shared}, 32'h1);
    @(negedge clk); wr_en = 1'b1; addr = 2'd2; wdata = 32'h1 << 25;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
    chk("R9 drops after clear", {31'b0, irq_shared}, 32'h0);
    chk("R8 direct kept", {21'b0, irq_direct}, 32'h1 << 3);
    clear_all();
    wr(2'd0, 32'h0);
    pins = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(2'd0, 32'h1 << 2);
    set_pin(2, 1'b1);
    set_pin(2, 1'b0);
    @(negedge clk); pins[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 2'd2; wdata = 32'h1 << 2;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
    rd(2'd2, d);
    chk("R7 edge wins over clear", d, 32'h1 << 2);
    clear_all();
    rd(2'd2, d);
    chk("R6 later clear", d, 32'h0);
    wr(2'd0, 32'h0);
    pins = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d);
    chk("R10 rise reg upper zero", d, 32'h0FFF_FFFF);
    wr(2'd1, 32'hA5A5_A5A5);
    rd(2'd1, d);
    chk("R10 fall reg", d, 32'h05A5_A5A5);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d);
    chk("R10 reserved addr", d, 32'h0);
    rd(2'd0, d);
    chk("R10 rise reg unaffected", d, 32'h0FFF_FFFF);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    rd(2'd2, d);
    chk("R10 status empty", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_mask();
    t_w1c();
    t_race();
    t_map();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule